// File: doc/BRIEF.md
# Register Bitfield Execution Unit

This unit performs bitfield operations on a 32-bit data register. A field is described by an immediate offset and an immediate width taken from a 16-bit extension word. Offset 0 names the register's most significant bit, and the field runs toward lower bits. A field that runs past bit 0 continues at bit 31. The extension word also names a second register, which is the source for an insert and the destination for extracts and find-first-one.

A caller presents an operation code, the extension word, the destination register value and the second register value, together with a one-cycle strobe. On the next clock edge the unit registers the results and raises a single-cycle done pulse. The results are the new destination value, the new second-register value, one write enable for each register, the second register's index, the condition flags, and a flag for unsupported operations. The unit handles only the immediate form. An extension word that asks for a register-supplied offset or width produces the unsupported flag and no write.

Top module: `bfx_unit`

## Requirements
- R1: The extension word is decoded as follows: offset = bits 10:6, width code = bits 4:0 (code 0 means width 32), second-register index = bits 14:12. The index appears on `src_idx_o` with the results.
- R2: The field mask is `width` ones aligned to the MSB and then rotated right by `offset`, so a field can wrap from bit 0 to bit 31. Operation codes are: 0 test, 1 extract unsigned, 2 change, 3 extract signed, 4 clear, 5 find first one, 6 set, 7 insert.
- R3: The field is left-justified by rotating it left by `offset`. N is the top bit of the left-justified field and Z is 1 when that field is zero. V and C are 0 after every supported operation.
- R4: Extract unsigned writes the field to the second register, right-justified and zero-extended.
- R5: Extract signed writes the field to the second register, right-justified and sign-extended from the field's top bit.
- R6: Find first one scans at most `width` bits, starting from the field's MSB. It writes `offset` plus the number of zero bits that come before the first one. An all-zero field therefore gives `offset + width`.
- R7: Change inverts the field bits, clear zeroes them and set forces them to one. In all three cases every bit outside the field keeps its value.
- R8: Insert places the low `width` bits of the second register into the field position, leaving bits outside the field unchanged. N and Z are taken from the inserted value, left-justified.
- R9: Test writes neither register. Extract and find-first-one write only the second register. Change, clear, set and insert write only the destination register.
- R10: If extension bit 11 or bit 5 is set, `unsup_o` is 1 with the results, both write enables are 0, and the flags keep their previous values.
- R11: Results and a single-cycle `done_o` appear on the clock edge after `start_i`. Without a strobe, `done_o` and both write enables are 0.
- R12: After reset, `done_o`, both write enables, `unsup_o`, both data outputs and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle operation strobe |
| opc_i | input | 3 | Operation code |
| ext_i | input | 16 | Extension word |
| dst_i | input | 32 | Current destination register value |
| src_i | input | 32 | Current second register value |
| done_o | output | 1 | Result valid pulse |
| dst_o | output | 32 | New destination register value |
| dst_we_o | output | 1 | Destination write enable |
| src_o | output | 32 | New second register value |
| src_we_o | output | 1 | Second register write enable |
| src_idx_o | output | 3 | Second register index |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag (cleared) |
| flag_c_o | output | 1 | Carry flag (cleared) |
| unsup_o | output | 1 | Unsupported operation |

## Verification
The bench builds the unit with its default 32-bit data width, which matches the 5-bit offset and width fields in the extension word. With that width the bench can reach offsets near 31 whose fields wrap past bit 0, the width code 0 that selects a full 32-bit field, and find-first-one results up to offset plus 32. Every operation is checked against a bit-by-bit model that walks the field positions, rather than against masks and rotations.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  typedef enum logic [2:0] {
    BF_TST  = 3'd0,
    BF_EXTU = 3'd1,
    BF_CHG  = 3'd2,
    BF_EXTS = 3'd3,
    BF_CLR  = 3'd4,
    BF_FFO  = 3'd5,
    BF_SET  = 3'd6,
    BF_INS  = 3'd7
  } bf_op_e;

  // extension word field positions
  localparam int EXT_W      = 16;
  localparam int EXT_WID_LO = 0;
  localparam int EXT_WREG   = 5;
  localparam int EXT_OFF_LO = 6;
  localparam int EXT_OREG   = 11;
  localparam int EXT_IDX_LO = 12;
  localparam int IDX_W      = 3;
endpackage

// File: rtl/bfx_decode.sv
module bfx_decode #(
  parameter int DATA_W = 32,
  localparam int POS_W = $clog2(DATA_W),
  localparam int CNT_W = POS_W + 1
) (
  input  logic [bfx_pkg::EXT_W-1:0] ext,
  output logic [POS_W-1:0]          off,
  output logic [CNT_W-1:0]          wid,
  output logic [bfx_pkg::IDX_W-1:0] sidx,
  output logic                      imm_ok
);
  import bfx_pkg::*;

  logic [POS_W-1:0] wcode;

  always_comb begin
    off    = ext[EXT_OFF_LO +: POS_W];
    wcode  = ext[EXT_WID_LO +: POS_W];
    wid    = (wcode == '0) ? CNT_W'(DATA_W) : {1'b0, wcode};
    sidx   = ext[EXT_IDX_LO +: IDX_W];
    imm_ok = !ext[EXT_OREG] && !ext[EXT_WREG];
  end
endmodule

// File: rtl/bfx_mask.sv
module bfx_mask #(
  parameter int DATA_W = 32,
  localparam int POS_W = $clog2(DATA_W),
  localparam int CNT_W = POS_W + 1
) (
  input  logic [POS_W-1:0]  off,
  input  logic [CNT_W-1:0]  wid,
  output logic [DATA_W-1:0] mask
);
  localparam logic [DATA_W-1:0] ALL = '1;

  function automatic logic [DATA_W-1:0] rot_r(logic [DATA_W-1:0] v, logic [POS_W-1:0] s);
    logic [2*DATA_W-1:0] t;
    t = {v, v} >> s;
    return t[DATA_W-1:0];
  endfunction

  always_comb mask = rot_r(~(ALL >> wid), off);
endmodule

// File: rtl/bfx_datapath.sv
module bfx_datapath #(
  parameter int DATA_W = 32,
  localparam int POS_W = $clog2(DATA_W),
  localparam int CNT_W = POS_W + 1
) (
  input  bfx_pkg::bf_op_e   op,
  input  logic [POS_W-1:0]  off,
  input  logic [CNT_W-1:0]  wid,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] left,
  output logic [DATA_W-1:0] dst_nx,
  output logic [DATA_W-1:0] src_nx,
  output logic              dst_we,
  output logic              src_we,
  output logic              flag_n,
  output logic              flag_z
);
  import bfx_pkg::*;
  localparam logic [DATA_W-1:0] ALL = '1;

  function automatic logic [DATA_W-1:0] rot_l(logic [DATA_W-1:0] v, logic [POS_W-1:0] s);
    logic [2*DATA_W-1:0] t;
    t = {v, v} << s;
    return t[2*DATA_W-1:DATA_W];
  endfunction

  function automatic logic [DATA_W-1:0] rot_r(logic [DATA_W-1:0] v, logic [POS_W-1:0] s);
    logic [2*DATA_W-1:0] t;
    t = {v, v} >> s;
    return t[DATA_W-1:0];
  endfunction

  // leading zeros of a left-justified field, capped at its width
  function automatic logic [CNT_W-1:0] lead_zeros(logic [DATA_W-1:0] v, logic [CNT_W-1:0] w);
    logic [CNT_W-1:0] n;
    logic             hit;
    n   = '0;
    hit = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (!hit && (CNT_W'(i) < w)) begin
        if (v[DATA_W-1-i]) hit = 1'b1;
        else               n   = n + 1'b1;
      end
    end
    return n;
  endfunction

  logic [CNT_W-1:0]         rsh;
  logic [DATA_W-1:0]        ins_left;
  logic [DATA_W-1:0]        flag_src;
  logic signed [DATA_W-1:0] left_s;

  always_comb begin
    rsh      = CNT_W'(DATA_W) - wid;
    left     = rot_l(dst & mask, off);
    left_s   = left;
    ins_left = (src & ~(ALL << wid)) << rsh;
    flag_src = (op == BF_INS) ? ins_left : left;
    flag_n   = flag_src[DATA_W-1];
    flag_z   = (flag_src == '0);

    dst_nx = dst;
    src_nx = src;
    dst_we = 1'b0;
    src_we = 1'b0;
    unique case (op)
      BF_TST: ;
      BF_EXTU: begin src_nx = left >> rsh;            src_we = 1'b1; end
      BF_EXTS: begin src_nx = DATA_W'(left_s >>> rsh); src_we = 1'b1; end
      BF_FFO: begin
        src_nx = DATA_W'(off) + DATA_W'(lead_zeros(left, wid));
        src_we = 1'b1;
      end
      BF_CHG: begin dst_nx = dst ^ mask;  dst_we = 1'b1; end
      BF_CLR: begin dst_nx = dst & ~mask; dst_we = 1'b1; end
      BF_SET: begin dst_nx = dst | mask;  dst_we = 1'b1; end
      BF_INS: begin
        dst_nx = (dst & ~mask) | rot_r(ins_left, off);
        dst_we = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit #(
  parameter int DATA_W = 32,
  localparam int POS_W = $clog2(DATA_W),
  localparam int CNT_W = POS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        opc_i,
  input  logic [15:0]       ext_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic              done_o,
  output logic [DATA_W-1:0] dst_o,
  output logic              dst_we_o,
  output logic [DATA_W-1:0] src_o,
  output logic              src_we_o,
  output logic [2:0]        src_idx_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_v_o,
  output logic              flag_c_o,
  output logic              unsup_o
);
  import bfx_pkg::*;

  logic [POS_W-1:0]  off_w;
  logic [CNT_W-1:0]  wid_w;
  logic [2:0]        sidx_w;
  logic              imm_ok_w;
  logic [DATA_W-1:0] mask_w;
  logic [DATA_W-1:0] left_w;
  logic [DATA_W-1:0] dst_nx_w, src_nx_w;
  logic              dst_we_w, src_we_w, n_w, z_w;
  logic              accept_w;
  bf_op_e            op_w;

  assign op_w     = bf_op_e'(opc_i);
  assign accept_w = start_i && imm_ok_w;

  bfx_decode #(.DATA_W(DATA_W)) dec_i (
    .ext(ext_i), .off(off_w), .wid(wid_w), .sidx(sidx_w), .imm_ok(imm_ok_w)
  );

  bfx_mask #(.DATA_W(DATA_W)) msk_i (
    .off(off_w), .wid(wid_w), .mask(mask_w)
  );

  bfx_datapath #(.DATA_W(DATA_W)) dp_i (
    .op(op_w), .off(off_w), .wid(wid_w), .mask(mask_w),
    .dst(dst_i), .src(src_i), .left(left_w),
    .dst_nx(dst_nx_w), .src_nx(src_nx_w),
    .dst_we(dst_we_w), .src_we(src_we_w),
    .flag_n(n_w), .flag_z(z_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o    <= 1'b0;
      dst_we_o  <= 1'b0;
      src_we_o  <= 1'b0;
      unsup_o   <= 1'b0;
      dst_o     <= '0;
      src_o     <= '0;
      src_idx_o <= '0;
      flag_n_o  <= 1'b0;
      flag_z_o  <= 1'b0;
      flag_v_o  <= 1'b0;
      flag_c_o  <= 1'b0;
    end else begin
      done_o   <= start_i;
      dst_we_o <= accept_w && dst_we_w;
      src_we_o <= accept_w && src_we_w;
      unsup_o  <= start_i && !imm_ok_w;
      if (start_i) src_idx_o <= sidx_w;
      if (accept_w) begin
        dst_o    <= dst_nx_w;
        src_o    <= src_nx_w;
        flag_n_o <= n_w;
        flag_z_o <= z_w;
        flag_v_o <= 1'b0;
        flag_c_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [DATA_W-1:0] mask_w,
  input logic              done_o,
  input logic [DATA_W-1:0] dst_o,
  input logic              dst_we_o,
  input logic              src_we_o,
  input logic              flag_n_o,
  input logic              flag_z_o,
  input logic              flag_v_o,
  input logic              flag_c_o,
  input logic              unsup_o
);
  p_done_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);

  p_no_idle_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (!done_o && !dst_we_o && !src_we_o));

  p_one_writer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dst_we_o, src_we_o}));

  p_unsup_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_o |-> (!dst_we_o && !src_we_o && done_o));

  p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_o |-> ($stable(flag_n_o) && $stable(flag_z_o)));

  p_vc_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !unsup_o) |-> (!flag_v_o && !flag_c_o));

  p_outside_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we_o |-> (((dst_o ^ $past(dst_i)) & ~$past(mask_w)) == '0));

  p_nz_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z_o |-> !flag_n_o);
endmodule

bind bfx_unit bfx_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .dst_i(dst_i),
  .mask_w(mask_w), .done_o(done_o), .dst_o(dst_o),
  .dst_we_o(dst_we_o), .src_we_o(src_we_o),
  .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
  .flag_v_o(flag_v_o), .flag_c_o(flag_c_o), .unsup_o(unsup_o)
);

// File: tb/bfx_unit_tb_top.sv
`timescale 1ns/1ps
module bfx_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  opc_i = '0;
  logic [15:0] ext_i = '0;
  logic [31:0] dst_i = '0, src_i = '0;
  logic        done_o, dst_we_o, src_we_o;
  logic [31:0] dst_o, src_o;
  logic [2:0]  src_idx_o;
  logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o, unsup_o;

  int n_run = 0;
  int n_fail = 0;
  logic prev_n = 1'b0, prev_z = 1'b0;

  always #2.5 clk = ~clk;

  bfx_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .opc_i(opc_i), .ext_i(ext_i),
    .dst_i(dst_i), .src_i(src_i), .done_o(done_o), .dst_o(dst_o),
    .dst_we_o(dst_we_o), .src_o(src_o), .src_we_o(src_we_o),
    .src_idx_o(src_idx_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
    .flag_v_o(flag_v_o), .flag_c_o(flag_c_o), .unsup_o(unsup_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Runs one operation and checks every output against a bit-walk model.
  task automatic run_op(string tag, int op, int off, int wcode, logic [31:0] d,
                        logic [31:0] s, logic [15:0] extra);
    int w, pos, first;
    logic [31:0] exp_d, exp_s, fld_r;
    logic en, es, exp_n, exp_z, bad;
    w = (wcode == 0) ? 32 : wcode;
    bad = (extra[11] | extra[5]);
    exp_d = d; exp_s = s; fld_r = '0; first = -1;
    for (int i = 0; i < w; i++) begin
      pos = 31 - ((off + i) % 32);
      fld_r[w-1-i] = d[pos];
      if (first < 0 && d[pos]) first = i;
      case (op)
        2: exp_d[pos] = ~d[pos];
        4: exp_d[pos] = 1'b0;
        6: exp_d[pos] = 1'b1;
        7: exp_d[pos] = s[w-1-i];
        default: ;
      endcase
    end
    if (op == 7) begin
      exp_n = s[w-1];
      exp_z = 1'b1;
      for (int i = 0; i < w; i++) if (s[i]) exp_z = 1'b0;
    end else begin
      exp_n = fld_r[w-1];
      exp_z = (fld_r == 0);
    end
    en = (op == 2 || op == 4 || op == 6 || op == 7);
    es = (op == 1 || op == 3 || op == 5);
    if (op == 1) exp_s = fld_r;
    if (op == 3) begin
      exp_s = fld_r;
      for (int i = w; i < 32; i++) exp_s[i] = fld_r[w-1];
    end
    if (op == 5) exp_s = off + ((first < 0) ? w : first);

    @(negedge clk);
    opc_i = op[2:0];
    ext_i = extra | 16'(((s[2:0] ^ 3'd5) << 12)) | 16'(off << 6) | 16'(wcode);
    dst_i = d; src_i = s; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk({tag, " R11 done"}, 32'(done_o), 1);
    chk({tag, " R1 index"}, 32'(src_idx_o), 32'(s[2:0] ^ 3'd5));
    chk({tag, " R10 unsup"}, 32'(unsup_o), 32'(bad));
    chk({tag, " R9 dst_we"}, 32'(dst_we_o), 32'(en && !bad));
    chk({tag, " R9 src_we"}, 32'(src_we_o), 32'(es && !bad));
    if (bad) begin
      chk({tag, " R10 n held"}, 32'(flag_n_o), 32'(prev_n));
      chk({tag, " R10 z held"}, 32'(flag_z_o), 32'(prev_z));
    end else begin
      chk({tag, " R3 N"}, 32'(flag_n_o), 32'(exp_n));
      chk({tag, " R3 Z"}, 32'(flag_z_o), 32'(exp_z));
      chk({tag, " R3 V"}, 32'(flag_v_o), 0);
      chk({tag, " R3 C"}, 32'(flag_c_o), 0);
      if (en) chk({tag, " dst"}, dst_o, exp_d);
      if (es) chk({tag, " src"}, src_o, exp_s);
      prev_n = exp_n; prev_z = exp_z;
    end
    @(negedge clk);
    chk({tag, " R11 done drops"}, 32'(done_o), 0);
    chk({tag, " R11 no idle write"}, 32'(dst_we_o | src_we_o), 0);
  endtask

  task automatic t_reset();
    chk("R12 done", 32'(done_o), 0);
    chk("R12 we", 32'({dst_we_o, src_we_o}), 0);
    chk("R12 unsup", 32'(unsup_o), 0);
    chk("R12 data", dst_o | src_o, 0);
    chk("R12 flags", 32'({flag_n_o, flag_z_o, flag_v_o, flag_c_o}), 0);
  endtask

  task automatic t_test_op();
    run_op("R2 test top", 0, 0, 8, 32'h8000_0000, 32'h1, 16'h0);
    run_op("R2 test zero", 0, 4, 4, 32'hF0FF_FFFF, 32'h2, 16'h0);
  endtask

  task automatic t_extract();
    run_op("R4 extu wrap", 1, 28, 8, 32'hA000_000B, 32'h0, 16'h0);
    run_op("R5 exts wrap", 3, 28, 8, 32'hA000_000B, 32'h0, 16'h0);
    run_op("R5 exts pos", 3, 3, 5, 32'h1E00_0000, 32'h0, 16'h0);
    run_op("R1 exts full", 3, 0, 0, 32'h9234_5678, 32'h0, 16'h0);
    run_op("R4 extu full off", 1, 12, 0, 32'h1234_5678, 32'h0, 16'h0);
  endtask

  task automatic t_ffo();
    run_op("R6 ffo hit", 5, 5, 10, 32'h0020_0000, 32'h0, 16'h0);
    run_op("R6 ffo empty", 5, 7, 9, 32'hFF00_007F, 32'h0, 16'h0);
    run_op("R6 ffo full zero", 5, 0, 0, 32'h0, 32'h0, 16'h0);
    run_op("R6 ffo wrap", 5, 30, 6, 32'h0000_0000 | 32'h2000_0000, 32'h0, 16'h0);
  endtask

  task automatic t_modify();
    run_op("R7 chg wrap", 2, 30, 6, 32'h5555_AAAA, 32'h0, 16'h0);
    run_op("R7 clr wrap", 4, 30, 6, 32'hFFFF_FFFF, 32'h0, 16'h0);
    run_op("R7 set mid", 6, 9, 13, 32'h0000_0000, 32'h0, 16'h0);
    run_op("R7 chg full", 2, 17, 0, 32'h0F0F_0F0F, 32'h0, 16'h0);
  endtask

  task automatic t_insert();
    run_op("R8 ins wrap", 7, 30, 6, 32'h0000_0000, 32'h0000_002D, 16'h0);
    run_op("R8 ins zero val", 7, 10, 4, 32'hFFFF_FFFF, 32'hFFFF_FFF0, 16'h0);
    run_op("R8 ins full", 7, 8, 0, 32'h1234_5678, 32'h8000_0001, 16'h0);
  endtask

  task automatic t_unsup();
    run_op("R10 off reg", 6, 3, 4, 32'h0, 32'h0, 16'h0800);
    run_op("R10 wid reg", 1, 0, 0, 32'hFFFF_FFFF, 32'h0, 16'h0020);
    run_op("R10 both", 7, 1, 1, 32'h0, 32'h1, 16'h0820);
  endtask

  initial begin
    #20000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_test_op();
    t_extract();
    t_ffo();
    t_modify();
    t_insert();
    t_unsup();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule